// File: doc/BRIEF.md
# Audio Master Clock Divider

This block derives the master clock handed to an external audio codec from a fast reference clock. The reference belongs to one of two families. In the first family the master clock is a power-of-two sub-rate of 512 times the sample rate. In the second family it is a power-of-two sub-rate of 384 times the sample rate. A family select bit picks the family, and a 3-bit divide code picks the sub-rate within it. The block's clock `clk` runs at twice the family base rate, which is 1024·fs or 768·fs. Every output ratio is therefore produced by registers alone, with an exact 50% duty cycle. This also holds for the undivided base rate.

The output toggles only while the run bit is set, the gate bit is clear and the requested setting is legal for the selected family. A new setting, or a stop, is taken up only when a low phase of the output completes. Retuning or halting the clock therefore never produces a shortened pulse. An illegal family and code pair raises an error flag. It also keeps the output parked low from the next period boundary on.

Top module: `mclk_divider`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `mclk_out` and `cfg_err` are 0.
- R2: With `base_sel`=0 (512·fs family), `div_code` values 0, 1, 2, 3 and 4 give master clocks of 512, 256, 128, 64 and 32 times fs. Each high phase and each low phase lasts 2^`div_code` cycles of `clk`.
- R3: With `base_sel`=1 (384·fs family), `div_code` values 0, 1, 2 and 3 give 384, 192, 96 and 48 times fs, with the same phase lengths of 2^`div_code` cycles.
- R4: A setting is illegal when `div_code`=4 with `base_sel`=1, or when `div_code` is 5 to 7 with either family. An illegal setting never starts a new high phase: the output goes low at the end of the current period and stays low.
- R5: The output can only rise while `run_en`=1 and `clk_gate`=0. Clearing `run_en` or setting `clk_gate` stops the output at the end of the period in progress and holds it low.
- R6: A change of `div_code` or `base_sel` during operation takes effect only when a low phase completes. No high or low phase is ever shorter than the length set by the code in effect.
- R7: From the stopped state, the output goes high in the first cycle after a legal, enabled setting is presented at a clock edge.
- R8: `cfg_err` is a registered flag. In each cycle it shows whether the setting presented at the previous edge was illegal, whatever the state of `run_en` and `clk_gate`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock at twice the family base rate |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Run bit; 1 allows the output to toggle |
| clk_gate | input | 1 | Gate bit; 1 forces the output to stop |
| base_sel | input | 1 | Family select: 0 = 512·fs, 1 = 384·fs |
| div_code | input | 3 | Power-of-two sub-rate select |
| mclk_out | output | 1 | Master clock to the codec |
| cfg_err | output | 1 | Illegal family/code pair seen at the previous edge |

## Verification
The assertions check the following on every cycle:
- Each completed high phase has exactly the length set by the code in effect.
- The output never rises while it is gated off or while the setting is illegal.
- The error flag follows the legality of the previous setting.

Only the bench's scenarios can show the remaining behaviour, through a behavioural reference model compared every clock:
- The full periods and low-phase lengths for each ratio in both families.
- The deferral of a code change to the end of a low phase.
- The one-cycle start latency from the stopped state.

// File: rtl/mclkdiv_pkg.sv
package mclkdiv_pkg;
    parameter int CODE_W       = 3;
    parameter int MAX_CODE_512 = 4;
    parameter int MAX_CODE_384 = 3;

    localparam int NUM_CODES = 1 << CODE_W;
    localparam int CNT_W     = (MAX_CODE_512 > 0) ? MAX_CODE_512 : 1;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef enum logic {
        FAMILY_512 = 1'b0,
        FAMILY_384 = 1'b1
    } family_e;

    typedef struct packed {
        logic  en;
        code_t code;
    } div_cfg_t;

    // last count value of a half period for a given code
    function automatic cnt_t half_last(code_t c);
        int span;
        span = 1 << c;
        return cnt_t'(span - 1);
    endfunction
endpackage

// File: rtl/mclk_cfg_check.sv
module mclk_cfg_check
    import mclkdiv_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  family_e family,
    input  code_t   code,
    output logic    legal,
    output logic    err_q
);
    logic [NUM_CODES-1:0] ok_512;
    logic [NUM_CODES-1:0] ok_384;

    genvar k;
    generate
        for (k = 0; k < NUM_CODES; k++) begin : g_code
            assign ok_512[k] = (k <= MAX_CODE_512);
            assign ok_384[k] = (k <= MAX_CODE_384);
        end
    endgenerate

    always_comb begin
        unique case (family)
            FAMILY_512: legal = ok_512[code];
            FAMILY_384: legal = ok_384[code];
            default:    legal = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= ~legal;
    end
endmodule

// File: rtl/mclk_half_counter.sv
module mclk_half_counter
    import mclkdiv_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  div_cfg_t cfg,
    output logic     term
);
    cnt_t cnt;

    assign term = cfg.en && (cnt == half_last(cfg.code));

    always_ff @(posedge clk) begin
        if (rst)                 cnt <= '0;
        else if (!cfg.en || term) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/mclk_phase_ctrl.sv
module mclk_phase_ctrl
    import mclkdiv_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     req_en,
    input  code_t    req_code,
    input  logic     term,
    output div_cfg_t cfg_q,
    output logic     mclk_q
);
    div_cfg_t cfg_n;
    logic     mclk_n;
    logic     reload;

    // a fresh setting is taken only from idle or when a low phase ends
    assign reload = !cfg_q.en || (term && !mclk_q);

    always_comb begin
        cfg_n  = cfg_q;
        mclk_n = mclk_q;
        if (reload) begin
            cfg_n.en   = req_en;
            cfg_n.code = req_en ? req_code : cfg_q.code;
            mclk_n     = req_en;
        end else if (term) begin
            mclk_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            mclk_q <= 1'b0;
        end else begin
            cfg_q  <= cfg_n;
            mclk_q <= mclk_n;
        end
    end
endmodule

// File: rtl/mclk_divider.sv
module mclk_divider
    import mclkdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic              clk_gate,
    input  logic              base_sel,
    input  logic [CODE_W-1:0] div_code,
    output logic              mclk_out,
    output logic              cfg_err
);
    logic     legal;
    logic     req_en;
    logic     term;
    div_cfg_t cur_cfg;

    mclk_cfg_check u_cfg (
        .clk    (clk),
        .rst    (rst),
        .family (family_e'(base_sel)),
        .code   (div_code),
        .legal  (legal),
        .err_q  (cfg_err)
    );

    assign req_en = run_en && !clk_gate && legal;

    mclk_half_counter u_cnt (
        .clk  (clk),
        .rst  (rst),
        .cfg  (cur_cfg),
        .term (term)
    );

    mclk_phase_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .req_en   (req_en),
        .req_code (div_code),
        .term     (term),
        .cfg_q    (cur_cfg),
        .mclk_q   (mclk_out)
    );
endmodule

// File: rtl/mclk_divider_chk.sv
module mclk_divider_chk
    import mclkdiv_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              run_en,
    input logic              clk_gate,
    input logic              base_sel,
    input logic [CODE_W-1:0] div_code,
    input logic              mclk_out,
    input logic              cfg_err,
    input logic [CODE_W-1:0] act_code
);
    logic       bad_set;
    logic       prev_m;
    logic [7:0] run_len;

    assign bad_set = base_sel ? (int'(div_code) > MAX_CODE_384)
                              : (int'(div_code) > MAX_CODE_512);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_m  <= 1'b0;
            run_len <= 8'd0;
        end else begin
            prev_m  <= mclk_out;
            if (mclk_out != prev_m) run_len <= 8'd1;
            else if (run_len != 8'hFF) run_len <= run_len + 8'd1;
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!mclk_out && !cfg_err));

    a_r8_err_follows: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cfg_err == $past(bad_set)));

    a_r4_no_rise_illegal: assert property (@(posedge clk) disable iff (rst)
        (bad_set && !mclk_out) |=> !mclk_out);

    a_r5_no_rise_off: assert property (@(posedge clk) disable iff (rst)
        ((!run_en || clk_gate) && !mclk_out) |=> !mclk_out);

    a_r6_high_width: assert property (@(posedge clk) disable iff (rst)
        (prev_m && !mclk_out) |-> (int'(run_len) == (1 << act_code)));
endmodule

bind mclk_divider mclk_divider_chk chk (
    .clk      (clk),
    .rst      (rst),
    .run_en   (run_en),
    .clk_gate (clk_gate),
    .base_sel (base_sel),
    .div_code (div_code),
    .mclk_out (mclk_out),
    .cfg_err  (cfg_err),
    .act_code (cur_cfg.code)
);

// File: tb/mclk_divider_test.sv
module mclk_divider_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run_en = 1'b0;
    logic       clk_gate = 1'b0;
    logic       base_sel = 1'b0;
    logic [2:0] div_code = 3'd0;
    logic       mclk_out;
    logic       cfg_err;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 0;
    string cur_req  = "R1";

    always #10 clk = ~clk;

    mclk_divider uut (
        .clk(clk), .rst(rst), .run_en(run_en), .clk_gate(clk_gate),
        .base_sel(base_sel), .div_code(div_code),
        .mclk_out(mclk_out), .cfg_err(cfg_err)
    );

    // behavioural reference model
    bit m_on, m_lvl, m_err;
    int m_left, m_code;

    always @(posedge clk) begin
        bit ok, req;
        if (rst) begin
            m_on = 0; m_lvl = 0; m_err = 0; m_left = 0; m_code = 0;
        end else begin
            ok  = base_sel ? (div_code <= 3) : (div_code <= 4);
            req = run_en && !clk_gate && ok;
            m_err = !ok;
            if (!m_on) begin
                if (req) begin
                    m_on = 1; m_lvl = 1; m_code = div_code; m_left = 1 << div_code;
                end
            end else begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    if (m_lvl) begin
                        m_lvl = 0; m_left = 1 << m_code;
                    end else begin
                        m_on = req;
                        if (req) begin
                            m_lvl = 1; m_code = div_code; m_left = 1 << div_code;
                        end
                    end
                end
            end
        end
    end

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            check(cur_req, "mclk_out vs model", int'(mclk_out), int'(m_lvl));
            check(cur_req, "cfg_err vs model",  int'(cfg_err),  int'(m_err));
        end
    end

    task automatic set_cfg(bit r, bit g, bit b, int c);
        @(negedge clk);
        run_en = r; clk_gate = g; base_sel = b; div_code = 3'(c);
    endtask

    // measure one full high and low phase at the outputs
    task automatic measure(string req, int code);
        int hi, lo;
        hi = 0; lo = 0;
        while (mclk_out !== 1'b0) @(negedge clk);
        while (mclk_out !== 1'b1) @(negedge clk);
        while (mclk_out === 1'b1) begin hi++; @(negedge clk); end
        while (mclk_out === 1'b0) begin lo++; @(negedge clk); end
        check(req, "high phase length", hi, 1 << code);
        check(req, "low phase length",  lo, 1 << code);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1";
        check("R1", "mclk_out in reset", int'(mclk_out), 0);
        check("R1", "cfg_err in reset",  int'(cfg_err), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "mclk_out after reset", int'(mclk_out), 0);

        // R7: start latency from idle
        cur_req = "R7";
        set_cfg(1, 0, 0, 2);
        @(negedge clk);
        check("R7", "output high one cycle after start", int'(mclk_out), 1);

        cur_req = "R2";
        for (int c = 0; c <= 4; c++) begin
            set_cfg(1, 0, 0, c);
            measure("R2", c);
            measure("R2", c);
        end

        cur_req = "R3";
        for (int c = 0; c <= 3; c++) begin
            set_cfg(1, 0, 1, c);
            measure("R3", c);
            measure("R3", c);
        end

        // R6: code change mid-high phase is deferred
        cur_req = "R6";
        set_cfg(1, 0, 0, 3);
        measure("R6", 3);
        while (mclk_out !== 1'b1) @(negedge clk);
        set_cfg(1, 0, 0, 1);
        repeat (3) @(negedge clk);
        check("R6", "old high phase still running", int'(mclk_out), 1);
        measure("R6", 1);

        // R5: gate stops output
        cur_req = "R5";
        set_cfg(1, 0, 0, 2);
        measure("R5", 2);
        set_cfg(1, 1, 0, 2);
        repeat (20) @(negedge clk);
        check("R5", "gated output low", int'(mclk_out), 0);
        set_cfg(1, 0, 0, 2);
        measure("R5", 2);
        set_cfg(0, 0, 0, 2);
        repeat (20) @(negedge clk);
        check("R5", "stopped output low", int'(mclk_out), 0);

        // R4: illegal pairs
        cur_req = "R4";
        set_cfg(1, 0, 1, 4);
        @(negedge clk);
        check("R4", "err for 384 family code 4", int'(cfg_err), 1);
        repeat (40) @(negedge clk);
        check("R4", "output parked low", int'(mclk_out), 0);
        set_cfg(1, 0, 0, 7);
        @(negedge clk);
        check("R4", "err for code 7", int'(cfg_err), 1);
        check("R4", "output still low", int'(mclk_out), 0);
        set_cfg(1, 0, 0, 4);
        @(negedge clk);
        check("R4", "code 4 legal in 512 family", int'(cfg_err), 0);
        measure("R4", 4);

        // R8: flag independent of run/gate
        cur_req = "R8";
        set_cfg(0, 1, 1, 5);
        @(negedge clk);
        check("R8", "err while stopped", int'(cfg_err), 1);
        set_cfg(0, 1, 1, 0);
        @(negedge clk);
        check("R8", "err clears", int'(cfg_err), 0);
        repeat (40) @(negedge clk);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL %s watchdog expired: actual running expected finished", cur_req);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule